// File: doc/BRIEF.md
# Configurable Register Field with Access Side Effects

This block is one field of a memory-mapped register. Software reaches it through a read strobe, a write strobe and write data. Hardware reaches it through write data, a write enable, set and clear inputs, and per-bit enable and mask vectors. Elaboration parameters choose the following:

- the width and the reset value;
- how a software write combines with the stored bits;
- whether a read leaves a side effect;
- whether the field acts as a self-clearing pulse;
- whether software writes need a qualifier input;
- how hardware writes are limited bit by bit.

Address decoding and the bus protocol sit outside the block. When the field is selected, the surrounding register logic raises `swRd` or `swWr` for one cycle. It takes the read value from `fieldVal` during that same cycle. The field reports each software touch on two strobes, and it can also give AND, OR and XOR reductions of its bits to nearby logic.

Top module: `sidefx_field`

## Requirements
- R1: While `rstN` is low, the field holds `RESET_VAL`. `swMod` and `swAcc` are low whenever no strobe is asserted.
- R2: A qualified software write sets the next value from the current value c and the data d according to `WR_MODE`:
  - PLAIN gives d.
  - ONE_SET gives c|d. ONE_CLR gives c&~d. ONE_TOG gives c^d.
  - ZERO_CLR gives c&d. ZERO_SET gives c|~d. ZERO_TOG gives c^~d.
  - ANY_CLR gives all zeros. ANY_SET gives all ones.
- R3: When `SW_WE_USE` is 1, a software write takes effect only when `swWe` equals `SW_WE_POL`. Otherwise the field keeps its value.
- R4: A read with `RD_FX` = RD_CLR makes the field all zeros on the next clock. A read with RD_SET makes it all ones. During the read cycle, `fieldVal` still shows the value from before the read. A qualified write in the same cycle overrides the read side effect.
- R5: When `PULSE_MODE` is 1, a value written by software is held for exactly one clock. The field then returns to zero by itself unless it is updated again.
- R6: `swMod` is high in a cycle in which software changes the field: either a qualified write, or a read while `RD_FX` is not RD_KEEP.
- R7: `swAcc` is high in any cycle with `swRd` or `swWr` high, even when the write is not qualified.
- R8: `hwClr` forces all bits to 0 and `hwSet` forces all bits to 1. Both work without a hardware write. Clear wins when both are high.
- R9: A hardware write loads `hwWrData` only when `hwWe` equals `HW_WE_POL`.
- R10: When `HW_QUAL` is ENABLE, a hardware write changes only the bits where `hwEn` is 1. When it is MASK, it changes only the bits where `hwMask` is 0.
- R11: When `REDUCE_EN` is 1, `andR`, `orR` and `xorR` are the AND, OR and XOR of the current field bits.
- R12: When software and hardware update the field in the same cycle, the software result is stored.
- R13: When no update of any kind occurs and the field is not in pulse mode, it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| swRd | input | 1 | Software read strobe |
| swWr | input | 1 | Software write strobe |
| swWe | input | 1 | Software write qualifier, polarity set by `SW_WE_POL` |
| swWrData | input | WIDTH | Software write data |
| hwWe | input | 1 | Hardware write enable, polarity set by `HW_WE_POL` |
| hwWrData | input | WIDTH | Hardware write data |
| hwSet | input | 1 | Force all bits to 1 |
| hwClr | input | 1 | Force all bits to 0 |
| hwEn | input | WIDTH | Per-bit hardware update enable |
| hwMask | input | WIDTH | Per-bit hardware update block |
| fieldVal | output | WIDTH | Current field value and read data |
| swMod | output | 1 | Software modified the field this cycle |
| swAcc | output | 1 | Software accessed the field this cycle |
| andR | output | 1 | AND reduction of the field |
| orR | output | 1 | OR reduction of the field |
| xorR | output | 1 | XOR reduction of the field |

## Verification
All nine write modes receive the same two data words one after the other, so each combining rule is seen from two different starting values. A swapped mode would leave a wrong bit pattern. The bench checks read data during the read cycle itself. A design that applied the side effect too early would return zeros instead of the stored value.

The bench drives a blocked write, a simultaneous set and clear, and a software write in the same cycle as a hardware set. A design with the wrong qualifier polarity or the wrong priority would store the value from the losing source. Pulse mode is checked one cycle and two cycles after the write, which catches a pulse that lasts too long or never appears.

// File: rtl/sfld_pkg.sv
package sfld_pkg;

  typedef enum logic [1:0] {
    RD_KEEP,
    RD_CLR,
    RD_SET
  } rdfx_e;

  typedef enum logic [3:0] {
    WM_PLAIN,
    WM_ONE_SET,
    WM_ONE_CLR,
    WM_ONE_TOG,
    WM_ZERO_CLR,
    WM_ZERO_SET,
    WM_ZERO_TOG,
    WM_ANY_CLR,
    WM_ANY_SET
  } wrmode_e;

  typedef enum logic [1:0] {
    HQ_NONE,
    HQ_ENABLE,
    HQ_MASK
  } hwqual_e;

  // one-hot update selection handed from control to datapath
  typedef struct packed {
    logic swLoad;
    logic rdClr;
    logic rdSet;
    logic hwForceClr;
    logic hwForceSet;
    logic hwLoad;
    logic pulseDrop;
  } fieldCtl_t;

endpackage

// File: rtl/sfld_ctrl.sv
module sfld_ctrl #(
  parameter sfld_pkg::rdfx_e RD_FX      = sfld_pkg::RD_KEEP,
  parameter bit              PULSE_MODE = 1'b0,
  parameter bit              SW_WE_USE  = 1'b0,
  parameter bit              SW_WE_POL  = 1'b1,
  parameter bit              HW_WE_POL  = 1'b1
) (
  input  logic                  swRd,
  input  logic                  swWr,
  input  logic                  swWe,
  input  logic                  hwWe,
  input  logic                  hwSet,
  input  logic                  hwClr,
  output sfld_pkg::fieldCtl_t   ctl,
  output logic                  swMod,
  output logic                  swAcc
);
  localparam bit READ_HAS_FX = (RD_FX != sfld_pkg::RD_KEEP);

  logic swWrOk;
  logic rdFx;
  logic swAct;
  logic hwWrOk;

  always_comb begin
    swWrOk = swWr & (SW_WE_USE ? (swWe == SW_WE_POL) : 1'b1);
    rdFx   = swRd & READ_HAS_FX;
    swAct  = swWrOk | rdFx;
    hwWrOk = (hwWe == HW_WE_POL);

    // software wins over hardware; a write wins over a read side effect
    ctl.swLoad     = swWrOk;
    ctl.rdClr      = rdFx & ~swWrOk & (RD_FX == sfld_pkg::RD_CLR);
    ctl.rdSet      = rdFx & ~swWrOk & (RD_FX == sfld_pkg::RD_SET);
    ctl.hwForceClr = ~swAct & hwClr;
    ctl.hwForceSet = ~swAct & ~hwClr & hwSet;
    ctl.hwLoad     = ~swAct & ~hwClr & ~hwSet & hwWrOk;
    ctl.pulseDrop  = PULSE_MODE & ~swAct & ~hwClr & ~hwSet & ~hwWrOk;
  end

  assign swMod = swAct;
  assign swAcc = swRd | swWr;

endmodule

// File: rtl/sfld_dp.sv
module sfld_dp #(
  parameter int                WIDTH     = 8,
  parameter logic [WIDTH-1:0]  RESET_VAL = '0,
  parameter sfld_pkg::wrmode_e WR_MODE   = sfld_pkg::WM_PLAIN,
  parameter sfld_pkg::hwqual_e HW_QUAL   = sfld_pkg::HQ_NONE,
  parameter bit                REDUCE_EN = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  sfld_pkg::fieldCtl_t  ctl,
  input  logic [WIDTH-1:0]     swWrData,
  input  logic [WIDTH-1:0]     hwWrData,
  input  logic [WIDTH-1:0]     hwEn,
  input  logic [WIDTH-1:0]     hwMask,
  output logic [WIDTH-1:0]     q,
  output logic                 andR,
  output logic                 orR,
  output logic                 xorR
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] swNext;
  logic [WIDTH-1:0] hwUpd;
  logic [WIDTH-1:0] hwNext;
  logic [WIDTH-1:0] dNext;

  always_comb begin
    unique case (WR_MODE)
      sfld_pkg::WM_PLAIN:    swNext = swWrData;
      sfld_pkg::WM_ONE_SET:  swNext = q | swWrData;
      sfld_pkg::WM_ONE_CLR:  swNext = q & ~swWrData;
      sfld_pkg::WM_ONE_TOG:  swNext = q ^ swWrData;
      sfld_pkg::WM_ZERO_CLR: swNext = q & swWrData;
      sfld_pkg::WM_ZERO_SET: swNext = q | ~swWrData;
      sfld_pkg::WM_ZERO_TOG: swNext = q ^ ~swWrData;
      sfld_pkg::WM_ANY_CLR:  swNext = '0;
      default:               swNext = ALL_ONES;
    endcase
  end

  always_comb begin
    unique case (HW_QUAL)
      sfld_pkg::HQ_ENABLE: hwUpd = hwEn;
      sfld_pkg::HQ_MASK:   hwUpd = ~hwMask;
      default:             hwUpd = ALL_ONES;
    endcase
    hwNext = (q & ~hwUpd) | (hwWrData & hwUpd);
  end

  always_comb begin
    dNext = q;
    if (ctl.swLoad)          dNext = swNext;
    else if (ctl.rdClr)      dNext = '0;
    else if (ctl.rdSet)      dNext = ALL_ONES;
    else if (ctl.hwForceClr) dNext = '0;
    else if (ctl.hwForceSet) dNext = ALL_ONES;
    else if (ctl.hwLoad)     dNext = hwNext;
    else if (ctl.pulseDrop)  dNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) q <= RESET_VAL;
    else       q <= dNext;
  end

  generate
    if (REDUCE_EN) begin : gReduce
      assign andR = &q;
      assign orR  = |q;
      assign xorR = ^q;
    end else begin : gNoReduce
      assign andR = 1'b0;
      assign orR  = 1'b0;
      assign xorR = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/sidefx_field.sv
module sidefx_field #(
  parameter int                WIDTH      = 8,
  parameter logic [WIDTH-1:0]  RESET_VAL  = '0,
  parameter sfld_pkg::wrmode_e WR_MODE    = sfld_pkg::WM_PLAIN,
  parameter sfld_pkg::rdfx_e   RD_FX      = sfld_pkg::RD_KEEP,
  parameter sfld_pkg::hwqual_e HW_QUAL    = sfld_pkg::HQ_NONE,
  parameter bit                PULSE_MODE = 1'b0,
  parameter bit                SW_WE_USE  = 1'b0,
  parameter bit                SW_WE_POL  = 1'b1,
  parameter bit                HW_WE_POL  = 1'b1,
  parameter bit                REDUCE_EN  = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             swRd,
  input  logic             swWr,
  input  logic             swWe,
  input  logic [WIDTH-1:0] swWrData,
  input  logic             hwWe,
  input  logic [WIDTH-1:0] hwWrData,
  input  logic             hwSet,
  input  logic             hwClr,
  input  logic [WIDTH-1:0] hwEn,
  input  logic [WIDTH-1:0] hwMask,
  output logic [WIDTH-1:0] fieldVal,
  output logic             swMod,
  output logic             swAcc,
  output logic             andR,
  output logic             orR,
  output logic             xorR
);
  sfld_pkg::fieldCtl_t ctl;

  sfld_ctrl #(
    .RD_FX(RD_FX), .PULSE_MODE(PULSE_MODE), .SW_WE_USE(SW_WE_USE),
    .SW_WE_POL(SW_WE_POL), .HW_WE_POL(HW_WE_POL)
  ) uCtrl (
    .swRd(swRd), .swWr(swWr), .swWe(swWe), .hwWe(hwWe),
    .hwSet(hwSet), .hwClr(hwClr), .ctl(ctl), .swMod(swMod), .swAcc(swAcc)
  );

  sfld_dp #(
    .WIDTH(WIDTH), .RESET_VAL(RESET_VAL), .WR_MODE(WR_MODE),
    .HW_QUAL(HW_QUAL), .REDUCE_EN(REDUCE_EN)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .swWrData(swWrData),
    .hwWrData(hwWrData), .hwEn(hwEn), .hwMask(hwMask), .q(fieldVal),
    .andR(andR), .orR(orR), .xorR(xorR)
  );

endmodule

// File: rtl/sidefx_field_chk.sv
module sidefx_field_chk #(
  parameter int                WIDTH      = 8,
  parameter sfld_pkg::rdfx_e   RD_FX      = sfld_pkg::RD_KEEP,
  parameter bit                PULSE_MODE = 1'b0,
  parameter bit                SW_WE_USE  = 1'b0,
  parameter bit                SW_WE_POL  = 1'b1,
  parameter bit                HW_WE_POL  = 1'b1
) (
  input logic             clk,
  input logic             rstN,
  input logic             swRd,
  input logic             swWr,
  input logic             swWe,
  input logic             hwWe,
  input logic             hwSet,
  input logic             hwClr,
  input logic [WIDTH-1:0] fieldVal,
  input logic             swMod,
  input logic             swAcc
);
  logic hwIdle;
  assign hwIdle = !hwSet && !hwClr && (hwWe != HW_WE_POL);

  a_r3_blocked_write: assert property (@(posedge clk) disable iff (!rstN)
    (SW_WE_USE && !PULSE_MODE && swWr && (swWe != SW_WE_POL) && !swRd && hwIdle)
      |=> $stable(fieldVal));

  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    ((RD_FX == sfld_pkg::RD_CLR) && swRd && !swWr) |=> (fieldVal == '0));

  a_r4_read_sets: assert property (@(posedge clk) disable iff (!rstN)
    ((RD_FX == sfld_pkg::RD_SET) && swRd && !swWr) |=> (fieldVal == '1));

  a_r5_pulse_returns: assert property (@(posedge clk) disable iff (!rstN)
    (PULSE_MODE && !swWr && !swRd && hwIdle) |=> (fieldVal == '0));

  a_r6_mod_implies_acc: assert property (@(posedge clk) disable iff (!rstN)
    swMod |-> swAcc);

  a_r8_force_clear: assert property (@(posedge clk) disable iff (!rstN)
    (hwClr && !swMod) |=> (fieldVal == '0));

  a_r8_force_set: assert property (@(posedge clk) disable iff (!rstN)
    (hwSet && !hwClr && !swMod) |=> (fieldVal == '1));

  a_r13_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!PULSE_MODE && !swWr && !swRd && hwIdle) |=> $stable(fieldVal));

endmodule

bind sidefx_field sidefx_field_chk #(
  .WIDTH(WIDTH), .RD_FX(RD_FX), .PULSE_MODE(PULSE_MODE),
  .SW_WE_USE(SW_WE_USE), .SW_WE_POL(SW_WE_POL), .HW_WE_POL(HW_WE_POL)
) uChk (
  .clk(clk), .rstN(rstN), .swRd(swRd), .swWr(swWr), .swWe(swWe),
  .hwWe(hwWe), .hwSet(hwSet), .hwClr(hwClr), .fieldVal(fieldVal),
  .swMod(swMod), .swAcc(swAcc)
);

// File: tb/sim_sidefx_field.sv
`timescale 1ns/1ps
module sim_sidefx_field;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       swRd = 1'b0, swWr = 1'b0, swWe = 1'b1;
  logic [7:0] swWrData = '0;
  logic       hwWe = 1'b0, hwWeN = 1'b1;
  logic [7:0] hwWrData = '0;
  logic       hwSet = 1'b0, hwClr = 1'b0;
  logic [7:0] hwEn = '0, hwMask = '0;

  int nChecks = 0;
  int nErr = 0;

  always #5 clk = ~clk;

  // u0: plain write, clear on read, per-bit enable, active-low sw qualifier
  logic [7:0] v0; logic mod0, acc0, and0, or0, xor0;
  sidefx_field #(
    .WIDTH(8), .RESET_VAL(8'hA5), .WR_MODE(sfld_pkg::WM_PLAIN),
    .RD_FX(sfld_pkg::RD_CLR), .HW_QUAL(sfld_pkg::HQ_ENABLE),
    .SW_WE_USE(1'b1), .SW_WE_POL(1'b0), .HW_WE_POL(1'b1)
  ) u0 (
    .clk(clk), .rstN(rstN), .swRd(swRd), .swWr(swWr), .swWe(swWe),
    .swWrData(swWrData), .hwWe(hwWe), .hwWrData(hwWrData), .hwSet(hwSet),
    .hwClr(hwClr), .hwEn(hwEn), .hwMask(hwMask), .fieldVal(v0),
    .swMod(mod0), .swAcc(acc0), .andR(and0), .orR(or0), .xorR(xor0)
  );

  // u1: toggle on ones, set on read, per-bit mask, active-low hw write
  logic [7:0] v1; logic mod1, acc1, and1, or1, xor1;
  sidefx_field #(
    .WIDTH(8), .RESET_VAL(8'h3C), .WR_MODE(sfld_pkg::WM_ONE_TOG),
    .RD_FX(sfld_pkg::RD_SET), .HW_QUAL(sfld_pkg::HQ_MASK), .HW_WE_POL(1'b0)
  ) u1 (
    .clk(clk), .rstN(rstN), .swRd(swRd), .swWr(swWr), .swWe(swWe),
    .swWrData(swWrData), .hwWe(hwWeN), .hwWrData(hwWrData), .hwSet(hwSet),
    .hwClr(hwClr), .hwEn(hwEn), .hwMask(hwMask), .fieldVal(v1),
    .swMod(mod1), .swAcc(acc1), .andR(and1), .orR(or1), .xorR(xor1)
  );

  // u2: single-pulse field, 4 bits
  logic [3:0] v2; logic mod2, acc2, and2, or2, xor2;
  sidefx_field #(
    .WIDTH(4), .RESET_VAL(4'h0), .PULSE_MODE(1'b1)
  ) u2 (
    .clk(clk), .rstN(rstN), .swRd(swRd), .swWr(swWr), .swWe(swWe),
    .swWrData(swWrData[3:0]), .hwWe(hwWe), .hwWrData(hwWrData[3:0]),
    .hwSet(1'b0), .hwClr(1'b0), .hwEn(hwEn[3:0]), .hwMask(hwMask[3:0]),
    .fieldVal(v2), .swMod(mod2), .swAcc(acc2), .andR(and2), .orR(or2), .xorR(xor2)
  );

  // one field per write mode, hardware side idle
  logic [7:0] modeVal [9];
  logic       modeMod [9], modeAcc [9], modeAnd [9], modeOr [9], modeXor [9];
  for (genvar m = 0; m < 9; m++) begin : gMode
    sidefx_field #(
      .WIDTH(8), .RESET_VAL(8'h5A), .WR_MODE(sfld_pkg::wrmode_e'(m))
    ) uM (
      .clk(clk), .rstN(rstN), .swRd(1'b0), .swWr(swWr), .swWe(1'b1),
      .swWrData(swWrData), .hwWe(1'b0), .hwWrData(8'h00), .hwSet(1'b0),
      .hwClr(1'b0), .hwEn(8'h00), .hwMask(8'h00), .fieldVal(modeVal[m]),
      .swMod(modeMod[m]), .swAcc(modeAcc[m]), .andR(modeAnd[m]),
      .orR(modeOr[m]), .xorR(modeXor[m])
    );
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] wrExpect(input int m, input logic [7:0] c, input logic [7:0] d);
    case (m)
      0: return d;
      1: return c | d;
      2: return c & ~d;
      3: return c ^ d;
      4: return c & d;
      5: return c | ~d;
      6: return c ^ ~d;
      7: return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idleInputs();
    swRd = 0; swWr = 0; swWe = 1; swWrData = '0;
    hwWe = 0; hwWeN = 1; hwWrData = '0; hwSet = 0; hwClr = 0;
    hwEn = '0; hwMask = '0;
  endtask

  task automatic applyReset();
    idleInputs();
    rstN = 0;
    tick(); tick();
    rstN = 1;
    tick();
  endtask

  task automatic tReset();
    applyReset();
    check("R1 u0 reset", v0, 8'hA5);
    check("R1 u1 reset", v1, 8'h3C);
    check("R1 u2 reset", v2, 4'h0);
    check("R1 mode reset", modeVal[4], 8'h5A);
    check("R1 strobes idle", {mod0, acc0}, 2'b00);
  endtask

  task automatic tModes();
    logic [7:0] cur [9];
    applyReset();
    for (int m = 0; m < 9; m++) cur[m] = 8'h5A;
    swWr = 1; swWrData = 8'h0F;
    tick();
    swWrData = 8'h3C;
    for (int m = 0; m < 9; m++) begin
      cur[m] = wrExpect(m, cur[m], 8'h0F);
      check($sformatf("R2 mode %0d first write", m), modeVal[m], cur[m]);
    end
    tick();
    swWr = 0;
    for (int m = 0; m < 9; m++) begin
      cur[m] = wrExpect(m, cur[m], 8'h3C);
      check($sformatf("R2 mode %0d second write", m), modeVal[m], cur[m]);
    end
    tick();
    check("R13 idle hold", modeVal[3], cur[3]);
  endtask

  task automatic tSwQualifier();
    applyReset();
    swWr = 1; swWe = 1; swWrData = 8'h11;
    #1;
    check("R7 blocked write still accessed", acc0, 1'b1);
    check("R6 blocked write not modified", mod0, 1'b0);
    tick();
    check("R3 blocked write ignored", v0, 8'hA5);
    swWe = 0;
    #1;
    check("R6 qualified write modifies", mod0, 1'b1);
    tick();
    swWr = 0; swWe = 1;
    check("R3 qualified write", v0, 8'h11);
  endtask

  task automatic tRead();
    applyReset();
    swRd = 1;
    #1;
    check("R4 read shows old value", v0, 8'hA5);
    check("R6 clearing read modifies", mod0, 1'b1);
    check("R7 read accessed", acc0, 1'b1);
    tick();
    swRd = 0;
    check("R4 clear on read", v0, 8'h00);
    check("R4 set on read", v1, 8'hFF);
    // a qualified write in the read cycle beats the side effect
    swRd = 1; swWr = 1; swWe = 0; swWrData = 8'h42;
    tick();
    idleInputs();
    check("R4 write beats read clear", v0, 8'h42);
  endtask

  task automatic tHardware();
    applyReset();
    hwWrData = 8'hFF; hwEn = 8'h0F; hwMask = 8'hF0;
    tick();
    check("R9 inactive hw write ignored u0", v0, 8'hA5);
    check("R9 inactive hw write ignored u1", v1, 8'h3C);
    hwWe = 1;
    tick();
    hwWe = 0;
    check("R10 enable vector", v0, 8'hAF);
    hwWrData = 8'h00; hwWeN = 0;
    tick();
    hwWeN = 1;
    check("R10 mask vector", v1, 8'h30);
  endtask

  task automatic tForce();
    applyReset();
    hwSet = 1;
    tick();
    check("R8 hw set", v0, 8'hFF);
    hwClr = 1;
    tick();
    hwSet = 0; hwClr = 0;
    check("R8 clear wins", v0, 8'h00);
    swWr = 1; swWe = 0; swWrData = 8'h12; hwSet = 1;
    tick();
    idleInputs();
    check("R12 software beats hardware", v0, 8'h12);
  endtask

  task automatic tPulse();
    applyReset();
    swWr = 1; swWrData = 8'h05;
    tick();
    idleInputs();
    check("R5 pulse high", v2, 4'h5);
    tick();
    check("R5 pulse gone", v2, 4'h0);
    tick();
    check("R5 pulse stays low", v2, 4'h0);
  endtask

  task automatic tReduce();
    applyReset();
    swWe = 0; swWr = 1; swWrData = 8'hFF;
    tick();
    check("R11 all ones", {and0, or0, xor0}, 3'b110);
    swWrData = 8'h07;
    tick();
    check("R11 three ones", {and0, or0, xor0}, 3'b011);
    swWrData = 8'h00;
    tick();
    idleInputs();
    check("R11 zero", {and0, or0, xor0}, 3'b000);
  endtask

  initial begin
    #2_000_000;
    nErr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    tReset();
    tModes();
    tSwQualifier();
    tRead();
    tHardware();
    tForce();
    tPulse();
    tReduce();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule